// File: doc/BRIEF.md
# Configuration-Memory Test Access Port

This block is the IEEE 1149.1 test access port of a configuration memory device. It contains the sixteen-state TAP state machine, an 8-bit instruction register, a 1-bit bypass register, a 32-bit identification register and a 32-bit user code register. It also decodes a device-specific reconfigure opcode. That opcode pulls an open-drain pin low for a fixed number of system-clock cycles, which restarts the loading of an attached programmable logic device.

TCK, TMS and TDI are oversampled in the system clock domain. TCK must therefore stay well below a quarter of the system clock rate. Every TAP action runs on the system clock, qualified by a detected rising or falling TCK edge. The instruction capture value is not fixed: it carries the live in-system-programming and read-lock status bits, so a host can read them without a dedicated instruction. The boundary-scan chain itself sits outside the block. When EXTEST or SAMPLE/PRELOAD is current, the block flags that chain as selected and passes its serial output to TDO.

Top module: `cfgmem_tap`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `tdo_oe`, `reconf_low`, `pins_hiz` and `ext_sel` are 0. The TAP starts in Test-Logic-Reset with the identification opcode (8'hFE) current, so a data scan taken straight after reset returns the identification value.
- R2: The TAP state follows the IEEE 1149.1 transition graph, advancing once per detected rising TCK edge on the sampled TMS. Five TCK rises with TMS high reach Test-Logic-Reset from any state, including Shift-DR. Test-Logic-Reset makes the identification opcode current again.
- R3: The instruction register is 8 bits and shifts LSB first. Capture-IR loads bit 0 = 1, bit 1 = 0, bit 2 = 0, bit 3 = `sec_lock`, bit 4 = `isp_mode` and bits 7:5 = 000. The shifted-in value becomes current in Update-IR.
- R4: Opcode decode: 8'hFE selects the identification register. 8'hFD selects the user code register. 8'h00 (EXTEST) and 8'h01 (SAMPLE/PRELOAD) select the external chain. Every other value, including 8'hFF, 8'hFA (CLAMP), 8'hFC (HIGHZ) and 8'hEE (reconfigure), selects the bypass register.
- R5: The bypass register captures 0 in Capture-DR and delays TDI by one TCK in Shift-DR.
- R6: The identification register captures {version[3:0], family[7:0], part[7:0], maker[10:0], 1'b1}, 32'h05026093 by default, and shifts out LSB first. After 32 shifts, TDI data follows on TDO.
- R7: The user code register reads 32'hFFFFFFFF until `uc_load` is pulsed. From then on it reads the `uc_value` latched on that pulse.
- R8: TDO and `tdo_oe` change only in the system cycle after a detected falling TCK edge. `tdo_oe` is 1 exactly after falls that occur in Shift-IR or Shift-DR.
- R9: When Update-IR makes 8'hEE current, `reconf_low` goes high for exactly `CF_CYCLES` system-clock cycles.
- R10: A reconfigure update that arrives while a pulse is running neither restarts nor stretches that pulse.
- R11: `pins_hiz` is 1 exactly while 8'hFC (HIGHZ) is the current opcode.
- R12: `ext_sel` is 1 exactly while 8'h00 or 8'h01 is current. While it is 1, Shift-DR presents `ext_so` on TDO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked here |
| rst_n | input | 1 | Asynchronous active-low reset |
| tck | input | 1 | Test clock, oversampled |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test serial data in |
| tdo | output | 1 | Test serial data out |
| tdo_oe | output | 1 | TDO driver enable; TDO is high impedance when 0 |
| isp_mode | input | 1 | Status: device is in in-system-programming mode |
| sec_lock | input | 1 | Status: read protection is set |
| uc_load | input | 1 | Single-cycle strobe latching `uc_value` |
| uc_value | input | 32 | New user code value |
| ext_so | input | 1 | Serial output of the external boundary chain |
| ext_sel | output | 1 | External boundary chain is the selected data register |
| pins_hiz | output | 1 | Command to float all functional outputs |
| reconf_low | output | 1 | Pull the open-drain reconfigure pin low when 1 |

## Verification
Every one of the 256 opcodes is loaded in turn. The two status inputs follow opcode bits 0 and 1, so the captured instruction value shows whether each status bit lands in its own position. Each load is followed by a 34-bit data scan of an irregular TDI pattern. The scan identifies the selected path by where the pattern reappears on TDO: after 1 bit for bypass, after 32 bits for the two code registers, and not at all for the external chain. Two reconfigure loads issued back to back, and then one on its own, separate a pulse restart from a correct one-shot. Forcing Test-Logic-Reset from the middle of Shift-DR checks that the reset path does not depend on the starting state.

// File: rtl/cfgmem_tap_pkg.sv
package cfgmem_tap_pkg;

  localparam int IR_W = 8;
  localparam int DR_W = 32;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SRC_BYP, SRC_ID, SRC_UC, SRC_EXT} dr_src_e;

  localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
  localparam logic [IR_W-1:0] OP_RECONF   = 8'hEE;
  localparam logic [IR_W-1:0] OP_CLAMP    = 8'hFA;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 8'hFC;
  localparam logic [IR_W-1:0] OP_USERCODE = 8'hFD;
  localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
  localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;

endpackage

// File: rtl/cfgmem_tap_fsm.sv
module cfgmem_tap_fsm
  import cfgmem_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tck_rise,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TLR;
    end else if (tck_rise) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  // R2
  tlr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_rise && tms && state_q == ST_TLR) |=> state_q == ST_TLR);

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tck_rise |=> $stable(state_q));

endmodule

// File: rtl/cfgmem_tap_ir.sv
module cfgmem_tap_ir
  import cfgmem_tap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic             tck_rise,
  input  logic             tck_fall,
  input  logic             tdi,
  input  logic             isp_mode,
  input  logic             sec_lock,
  output logic [IR_W-1:0]  ir_cur,
  output logic             ir_so,
  output logic             reconf_go
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic [IR_W-1:0] cur_q, cur_d;
  logic [IR_W-1:0] cap_val;

  assign cap_val = {3'b000, isp_mode, sec_lock, 1'b0, 2'b01};

  always_comb begin
    sr_d = sr_q;
    if (tck_rise) begin
      if (state == ST_CAP_IR) begin
        sr_d = cap_val;
      end else if (state == ST_SH_IR) begin
        sr_d = {tdi, sr_q[IR_W-1:1]};
      end
    end
  end

  always_comb begin
    cur_d = cur_q;
    if (state == ST_TLR) begin
      cur_d = OP_IDCODE;
    end else if (tck_fall && state == ST_UPD_IR) begin
      cur_d = sr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cur_q <= OP_IDCODE;
    end else begin
      sr_q  <= sr_d;
      cur_q <= cur_d;
    end
  end

  assign ir_cur    = cur_q;
  assign ir_so     = sr_q[0];
  assign reconf_go = tck_fall && (state == ST_UPD_IR) && (sr_q == OP_RECONF);

  // R3
  ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_rise && state == ST_CAP_IR) |=>
      (sr_q[1:0] == 2'b01 && !sr_q[2] && sr_q[7:5] == 3'b000));

  // R2
  ir_tlr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TLR) |=> cur_q == OP_IDCODE);

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_TLR && !tck_fall) |=> $stable(cur_q));

endmodule

// File: rtl/cfgmem_tap_dr.sv
module cfgmem_tap_dr
  import cfgmem_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [7:0]  ID_FAMILY  = 8'h50,
  parameter logic [7:0]  ID_PART    = 8'h26,
  parameter logic [10:0] ID_MAKER   = 11'h049
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic             tck_rise,
  input  logic             tdi,
  input  logic [IR_W-1:0]  ir_cur,
  input  logic             uc_load,
  input  logic [DR_W-1:0]  uc_value,
  input  logic             ext_so,
  output logic             dr_so,
  output logic             ext_sel,
  output logic             pins_hiz
);

  localparam logic [DR_W-1:0] ID_VALUE = {ID_VERSION, ID_FAMILY, ID_PART, ID_MAKER, 1'b1};

  dr_src_e         src;
  logic [DR_W-1:0] uc_q, uc_d;
  logic [DR_W-1:0] sr_q, sr_d;
  logic            byp_q, byp_d;
  logic            wide_sel;

  always_comb begin
    unique case (ir_cur)
      OP_IDCODE:             src = SRC_ID;
      OP_USERCODE:           src = SRC_UC;
      OP_EXTEST, OP_SAMPLE:  src = SRC_EXT;
      default:               src = SRC_BYP;
    endcase
  end

  assign wide_sel = (src == SRC_ID) || (src == SRC_UC);

  always_comb begin
    uc_d = uc_q;
    if (uc_load) begin
      uc_d = uc_value;
    end
  end

  always_comb begin
    sr_d  = sr_q;
    byp_d = byp_q;
    if (tck_rise) begin
      if (state == ST_CAP_DR) begin
        byp_d = 1'b0;
        if (src == SRC_ID) begin
          sr_d = ID_VALUE;
        end else if (src == SRC_UC) begin
          sr_d = uc_q;
        end
      end else if (state == ST_SH_DR) begin
        byp_d = tdi;
        if (wide_sel) begin
          sr_d = {tdi, sr_q[DR_W-1:1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_q  <= '1;
      sr_q  <= '0;
      byp_q <= 1'b0;
    end else begin
      uc_q  <= uc_d;
      sr_q  <= sr_d;
      byp_q <= byp_d;
    end
  end

  always_comb begin
    unique case (src)
      SRC_ID, SRC_UC: dr_so = sr_q[0];
      SRC_EXT:        dr_so = ext_so;
      default:        dr_so = byp_q;
    endcase
  end

  assign ext_sel  = (src == SRC_EXT);
  assign pins_hiz = (ir_cur == OP_HIGHZ);

  // R6
  id_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_rise && state == ST_CAP_DR && ir_cur == OP_IDCODE) |=> sr_q[0]);

  // R5
  byp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_rise && state == ST_CAP_DR) |=> !byp_q);

  // R7
  uc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uc_load |=> $stable(uc_q));

endmodule

// File: rtl/cfgmem_tap_reconf.sv
module cfgmem_tap_reconf #(
  parameter int CF_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic reconf_low
);

  localparam int CNT_W = $clog2(CF_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CF_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             low_q;
  logic             busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end else if (start) begin
      cnt_d = CNT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      low_q <= (cnt_d != '0);
    end
  end

  assign reconf_low = low_q;

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R9
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reconf_low) |-> $past(start));

  // R9
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reconf_low) |-> $past(cnt_q) == 1);

endmodule

// File: rtl/cfgmem_tap.sv
module cfgmem_tap
  import cfgmem_tap_pkg::*;
#(
  parameter int          CF_CYCLES  = 50,
  parameter int          SYNC_STG   = 2,
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [7:0]  ID_FAMILY  = 8'h50,
  parameter logic [7:0]  ID_PART    = 8'h26,
  parameter logic [10:0] ID_MAKER   = 11'h049
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tck,
  input  logic        tms,
  input  logic        tdi,
  output logic        tdo,
  output logic        tdo_oe,
  input  logic        isp_mode,
  input  logic        sec_lock,
  input  logic        uc_load,
  input  logic [31:0] uc_value,
  input  logic        ext_so,
  output logic        ext_sel,
  output logic        pins_hiz,
  output logic        reconf_low
);

  localparam int TCK_STG = SYNC_STG + 1;

  logic [TCK_STG-1:0]  tck_s;
  logic [SYNC_STG-1:0] tms_s, tdi_s;
  logic                tck_rise, tck_fall;
  logic                tms_v, tdi_v;

  tap_state_e          state;
  logic [IR_W-1:0]     ir_cur;
  logic                ir_so, dr_so, reconf_go;
  logic                tdo_q, tdo_d, oe_q, oe_d;

  // Input synchronisers; TMS/TDI use the same depth as TCK so they stay aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_s <= '0;
      tms_s <= '1;
      tdi_s <= '1;
    end else begin
      tck_s <= {tck_s[TCK_STG-2:0], tck};
      tms_s <= {tms_s[SYNC_STG-2:0], tms};
      tdi_s <= {tdi_s[SYNC_STG-2:0], tdi};
    end
  end

  assign tck_rise = tck_s[SYNC_STG-1] & ~tck_s[SYNC_STG];
  assign tck_fall = ~tck_s[SYNC_STG-1] & tck_s[SYNC_STG];
  assign tms_v    = tms_s[SYNC_STG-1];
  assign tdi_v    = tdi_s[SYNC_STG-1];

  cfgmem_tap_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tck_rise (tck_rise),
    .tms      (tms_v),
    .state    (state)
  );

  cfgmem_tap_ir u_ir (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .tck_rise  (tck_rise),
    .tck_fall  (tck_fall),
    .tdi       (tdi_v),
    .isp_mode  (isp_mode),
    .sec_lock  (sec_lock),
    .ir_cur    (ir_cur),
    .ir_so     (ir_so),
    .reconf_go (reconf_go)
  );

  cfgmem_tap_dr #(
    .ID_VERSION (ID_VERSION),
    .ID_FAMILY  (ID_FAMILY),
    .ID_PART    (ID_PART),
    .ID_MAKER   (ID_MAKER)
  ) u_dr (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .tck_rise (tck_rise),
    .tdi      (tdi_v),
    .ir_cur   (ir_cur),
    .uc_load  (uc_load),
    .uc_value (uc_value),
    .ext_so   (ext_so),
    .dr_so    (dr_so),
    .ext_sel  (ext_sel),
    .pins_hiz (pins_hiz)
  );

  cfgmem_tap_reconf #(
    .CF_CYCLES (CF_CYCLES)
  ) u_reconf (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (reconf_go),
    .reconf_low (reconf_low)
  );

  // TDO path: next value chosen here, registered on the falling TCK edge.
  always_comb begin
    oe_d  = (state == ST_SH_IR) || (state == ST_SH_DR);
    tdo_d = 1'b0;
    if (state == ST_SH_IR) begin
      tdo_d = ir_so;
    end else if (state == ST_SH_DR) begin
      tdo_d = dr_so;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (tck_fall) begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  // R8
  tdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdo) |-> $past(tck_fall));

  // R8
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdo_oe) |-> $past(tck_fall));

  // R8
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tck_rise && tck_fall));

endmodule

// File: tb/cfgmem_tap_tb_top.sv
module cfgmem_tap_tb_top;

  localparam int HALF  = 4;
  localparam int CF_N  = 150;
  localparam logic [31:0] IDC    = 32'h05026093;
  localparam logic [31:0] UC_NEW = 32'h1234ABCD;
  localparam logic [33:0] PAT    = 34'h2A5C30F96;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tck, tms, tdi;
  logic        tdo, tdo_oe;
  logic        isp_mode, sec_lock;
  logic        uc_load;
  logic [31:0] uc_value;
  logic        ext_so;
  logic        ext_sel, pins_hiz, reconf_low;

  int nvec = 0;
  int nerr = 0;
  logic smp_oe;
  logic done = 1'b0;

  int run_len = 0;
  int last_w  = 0;
  int npulse  = 0;

  always #4 clk = ~clk;

  cfgmem_tap #(.CF_CYCLES(CF_N)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tck        (tck),
    .tms        (tms),
    .tdi        (tdi),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe),
    .isp_mode   (isp_mode),
    .sec_lock   (sec_lock),
    .uc_load    (uc_load),
    .uc_value   (uc_value),
    .ext_so     (ext_so),
    .ext_sel    (ext_sel),
    .pins_hiz   (pins_hiz),
    .reconf_low (reconf_low)
  );

  always @(posedge clk) begin
    if (reconf_low) begin
      run_len++;
    end else if (run_len != 0) begin
      last_w = run_len;
      npulse++;
      run_len = 0;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tck_step(input logic m, input logic d, output logic so);
    tms = m;
    tdi = d;
    wait_clk(HALF);
    so     = tdo;
    smp_oe = tdo_oe;
    tck = 1'b1;
    wait_clk(HALF);
    tck = 1'b0;
  endtask

  task automatic ir_scan(input logic [7:0] op, output logic [7:0] cap);
    logic s;
    tck_step(1'b1, 1'b0, s);
    tck_step(1'b1, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
    for (int i = 0; i < 8; i++) begin
      tck_step(i == 7, op[i], s);
      cap[i] = s;
    end
    tck_step(1'b1, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
  endtask

  task automatic dr_scan(input logic [33:0] pin, output logic [33:0] pout, output logic oe_all);
    logic s;
    oe_all = 1'b1;
    tck_step(1'b1, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
    for (int i = 0; i < 34; i++) begin
      tck_step(i == 33, pin[i], s);
      pout[i] = s;
      oe_all  = oe_all & smp_oe;
    end
    tck_step(1'b1, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nvec++;
    nerr++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0]  cap;
    logic [33:0] dout;
    logic [33:0] exp_v;
    logic        oe_all;
    logic        s;
    int          p0;
    string       tag;

    rst_n = 1'b0; tck = 1'b0; tms = 1'b1; tdi = 1'b1;
    isp_mode = 1'b0; sec_lock = 1'b0; uc_load = 1'b0; uc_value = '0; ext_so = 1'b1;
    smp_oe = 1'b0;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(1);

    // R1 reset state
    chk("R1 tdo_oe", 64'(tdo_oe), 64'd0);
    chk("R1 reconf_low", 64'(reconf_low), 64'd0);
    chk("R1 pins_hiz", 64'(pins_hiz), 64'd0);
    chk("R1 ext_sel", 64'(ext_sel), 64'd0);

    // R1/R6 identification selected straight from reset
    tck_step(1'b0, 1'b0, s);
    dr_scan(PAT, dout, oe_all);
    chk("R1 R6 idcode after reset", 64'(dout), 64'({PAT[1:0], IDC}));
    chk("R8 oe during shift-dr", 64'(oe_all), 64'd1);
    wait_clk(HALF);
    chk("R8 oe released in idle", 64'(tdo_oe), 64'd0);

    // R7 default user code, then loaded value
    ir_scan(8'hFD, cap);
    chk("R3 capture pattern idle status", 64'(cap), 64'h01);
    dr_scan(PAT, dout, oe_all);
    chk("R7 usercode default", 64'(dout), 64'({PAT[1:0], 32'hFFFFFFFF}));
    uc_value = UC_NEW;
    uc_load  = 1'b1;
    wait_clk(1);
    uc_load  = 1'b0;
    uc_value = 32'h0;
    dr_scan(PAT, dout, oe_all);
    chk("R7 usercode loaded", 64'(dout), 64'({PAT[1:0], UC_NEW}));

    // R9 R10 reconfigure pulse, second request during pulse ignored
    wait_clk(20);
    p0 = npulse;
    ir_scan(8'hEE, cap);
    ir_scan(8'hEE, cap);
    wait_clk(2 * CF_N + 50);
    chk("R10 one pulse for overlapping requests", 64'(npulse - p0), 64'd1);
    chk("R10 width not stretched", 64'(last_w), 64'(CF_N));
    p0 = npulse;
    ir_scan(8'hEE, cap);
    wait_clk(CF_N + 50);
    chk("R9 pulse count", 64'(npulse - p0), 64'd1);
    chk("R9 pulse width", 64'(last_w), 64'(CF_N));

    // R2 Test-Logic-Reset from inside Shift-DR restores identification
    ir_scan(8'hFF, cap);
    tck_step(1'b1, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
    for (int i = 0; i < 5; i++) tck_step(1'b1, 1'b0, s);
    tck_step(1'b0, 1'b0, s);
    dr_scan(PAT, dout, oe_all);
    chk("R2 tlr from shift-dr", 64'(dout), 64'({PAT[1:0], IDC}));

    // Full opcode sweep: R3 R4 R5 R6 R7 R11 R12
    p0 = npulse;
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      isp_mode = o[0];
      sec_lock = o[1];
      ir_scan(o, cap);
      chk("R3 capture pattern", 64'(cap), 64'({3'b000, o[0], o[1], 1'b0, 2'b01}));
      chk("R11 pins_hiz", 64'(pins_hiz), 64'(o == 8'hFC));
      chk("R12 ext_sel", 64'(ext_sel), 64'(o == 8'h00 || o == 8'h01));
      dr_scan(PAT, dout, oe_all);
      if (o == 8'hFE) begin
        exp_v = {PAT[1:0], IDC}; tag = "R6 idcode path";
      end else if (o == 8'hFD) begin
        exp_v = {PAT[1:0], UC_NEW}; tag = "R7 usercode path";
      end else if (o == 8'h00 || o == 8'h01) begin
        exp_v = '1; tag = "R12 external chain path";
      end else begin
        exp_v = {PAT[32:0], 1'b0}; tag = "R4 R5 bypass path";
      end
      chk(tag, 64'(dout), 64'(exp_v));
    end
    wait_clk(CF_N + 50);
    chk("R9 single pulse over sweep", 64'(npulse - p0), 64'd1);

    summary();
  end

endmodule